// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request (bus number, device/function number and register offset) into the two values a host needs for a PCI configuration access. The first is the address offset to present inside the host's configuration window. The second is the value to load into the window's translation (map) register. A request on bus zero becomes a Type 0 cycle, and any other bus becomes a Type 1 cycle for a segment behind a bridge.

In a Type 0 cycle the target device is picked by a single set bit. Slots 0 to 12 put that bit in the address. Higher slots move it into the map value, because the address window is too narrow to hold it. The map value also carries the configuration cycle-type code and the bit that chooses how the two lowest address lines are driven.

Each request is accepted on the cycle `reqValid` is high. The result appears on registered outputs one clock later, marked by `respValid`. Inputs above 255 are flagged and give all-zero outputs.

Top module: `cfgAddrGen`

## Requirements
- R1: After reset, `respValid`, `rangeErr`, `cfgAddr` and `mapVal` are all zero.
- R2: `respValid` is high for exactly the cycle after each cycle in which `reqValid` is high, and low otherwise.
- R3: Bus number 0 selects a Type 0 cycle, which clears `mapVal` bit 0 (A1:A0 forced to 00). A nonzero bus selects Type 1, which sets `mapVal` bit 0 (A1:A0 from the host).
- R4: In a Type 0 cycle the function number (devFn bits 2:0) lands in `cfgAddr` bits 10:8. For slot s = devFn bits 7:3 in 0..12, `cfgAddr` bit s+11 is the only set bit among bits 31:11.
- R5: In a Type 0 cycle with slot s in 13..31, `mapVal` bit s-5 is set and `cfgAddr` bits 31:11 are all zero.
- R6: In a Type 1 cycle the bus number fills `cfgAddr` bits 23:16, devFn fills bits 15:8, and bits 31:24 are zero. No device-select bit appears in `mapVal`.
- R7: For every legal request, `mapVal` bits 3:1 equal 3'b101. Its remaining bits are zero except for bit 0 and the R5 select bit.
- R8: The register offset is added to the generated address, so offset bits 7:0 appear in `cfgAddr` bits 7:0.
- R9: A request with any input above 255 sets `rangeErr` with `respValid` and drives `cfgAddr` and `mapVal` to zero. The next legal request clears `rangeErr`.
- R10: Between requests, `cfgAddr`, `mapVal` and `rangeErr` keep the values of the last response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, one request per high cycle |
| busIn | input | IN_W (10) | Bus number |
| devFnIn | input | IN_W (10) | Device (bits 7:3) and function (bits 2:0) |
| regOffIn | input | IN_W (10) | Configuration register offset |
| respValid | output | 1 | Result valid, one cycle after the request |
| rangeErr | output | 1 | Last request had an input above 255 |
| cfgAddr | output | ADDR_W (32) | Configuration window address offset |
| mapVal | output | MAP_W (32) | Value for the window map register |

## Verification
Type 0 requests are driven at slots 0, 12, 13 and 31. These cover both sides of the point where the select bit moves from the address into the map value, plus both extremes of the slot range. Type 1 requests use bus 1 and bus 255 with all-ones fields, which shows that the bus and devFn fields are placed without overlap or truncation. Nonzero function and offset values expose any wrong bit position. Out-of-range values are applied on each input in turn. A legal request follows to show the error clears, and idle cycles follow to show the outputs hold.

// File: rtl/cfgaddr_pkg.sv
package cfgaddr_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;   // capture a freshly computed address/map pair
    logic clear;  // force outputs to zero for a rejected request
  } cfgStrobe_t;

  localparam logic [2:0] CFG_CYCLE_CODE = 3'b101;

endpackage

// File: rtl/cfgaddr_ctrl.sv
module cfgaddr_ctrl
  import cfgaddr_pkg::*;
#(
  parameter int IN_W      = 10,
  parameter int LEGAL_MAX = 255
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [IN_W-1:0] busIn,
  input  logic [IN_W-1:0] devFnIn,
  input  logic [IN_W-1:0] regOffIn,
  output cfgStrobe_t      strobes,
  output logic            respValid,
  output logic            rangeErr
);

  localparam logic [IN_W-1:0] LIMIT = IN_W'(LEGAL_MAX);

  logic tooBig;

  always_comb begin
    tooBig        = (busIn > LIMIT) || (devFnIn > LIMIT) || (regOffIn > LIMIT);
    strobes.load  = reqValid && !tooBig;
    strobes.clear = reqValid && tooBig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      rangeErr  <= 1'b0;
    end else begin
      respValid <= reqValid;
      if (reqValid) rangeErr <= tooBig;
    end
  end

  assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (busIn > LIMIT)) |=> rangeErr);
  assert_err_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !rangeErr);

endmodule

// File: rtl/cfgaddr_dpath.sv
module cfgaddr_dpath
  import cfgaddr_pkg::*;
#(
  parameter int FIELD_W      = 8,
  parameter int ADDR_W       = 32,
  parameter int MAP_W        = 32,
  parameter int LOW_SLOT_MAX = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobes,
  input  logic [FIELD_W-1:0] busNum,
  input  logic [FIELD_W-1:0] devFn,
  input  logic [FIELD_W-1:0] regOff,
  output logic [ADDR_W-1:0]  cfgAddr,
  output logic [MAP_W-1:0]   mapVal
);

  localparam int FUNC_W       = 3;
  localparam int SLOT_W       = FIELD_W - FUNC_W;
  localparam int NUM_SLOTS    = 1 << SLOT_W;
  localparam int FUNC_LSB     = FIELD_W;
  localparam int DEV_LSB      = FUNC_LSB + FUNC_W;
  localparam int BUS_LSB      = 2 * FIELD_W;
  localparam int MAP_ADDR_LSB = 16;
  localparam int MAP_SHIFT    = MAP_ADDR_LSB - DEV_LSB;

  logic [SLOT_W-1:0]    slotNum;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [ADDR_W-1:0]    addrDevSel;
  logic [MAP_W-1:0]     mapDevSel;
  logic [ADDR_W-1:0]    addrBase;
  logic [ADDR_W-1:0]    addrNext;
  logic [MAP_W-1:0]     mapNext;
  logic                 isLocal;

  assign slotNum = devFn[FIELD_W-1:FUNC_W];
  assign isLocal = (busNum == '0);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slotHit[g] = (slotNum == SLOT_W'(g));
  end

  always_comb begin
    addrDevSel = '0;
    mapDevSel  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (s <= LOW_SLOT_MAX) addrDevSel[s + DEV_LSB]   = slotHit[s];
      else                   mapDevSel[s - MAP_SHIFT]  = slotHit[s];
    end
  end

  always_comb begin
    addrBase   = '0;
    mapNext    = '0;
    mapNext[3:1] = CFG_CYCLE_CODE;
    if (isLocal) begin
      addrBase[FUNC_LSB +: FUNC_W] = devFn[FUNC_W-1:0];
      addrBase = addrBase | addrDevSel;
      mapNext  = mapNext | mapDevSel;
    end else begin
      mapNext[0] = 1'b1;
      addrBase[BUS_LSB +: FIELD_W]  = busNum;
      addrBase[FUNC_LSB +: FIELD_W] = devFn;
    end
    addrNext = addrBase + ADDR_W'(regOff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddr <= '0;
      mapVal  <= '0;
    end else if (strobes.clear) begin
      cfgAddr <= '0;
      mapVal  <= '0;
    end else if (strobes.load) begin
      cfgAddr <= addrNext;
      mapVal  <= mapNext;
    end
  end

  assert_cycle_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> mapVal[3:1] == 3'b101);
  assert_bus_kind_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> mapVal[0] == ($past(busNum) != '0));
  assert_dev_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && isLocal) |=> $onehot0(cfgAddr[ADDR_W-1:DEV_LSB]));
  assert_high_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && isLocal && (slotNum > SLOT_W'(LOW_SLOT_MAX)))
      |=> (cfgAddr[ADDR_W-1:DEV_LSB] == '0) && ($countones(mapVal[MAP_W-1:4]) == 1));
  assert_type1_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !isLocal) |=> (cfgAddr[ADDR_W-1:BUS_LSB+FIELD_W] == '0)
      && (mapVal[MAP_W-1:4] == '0));
  assert_offset_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> cfgAddr[FIELD_W-1:0] == $past(regOff));
  assert_zero_on_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (cfgAddr == '0) && (mapVal == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.clear) |=> $stable(cfgAddr) && $stable(mapVal));

endmodule

// File: rtl/cfgAddrGen.sv
module cfgAddrGen
  import cfgaddr_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int ADDR_W = 32,
  parameter int MAP_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IN_W-1:0]   busIn,
  input  logic [IN_W-1:0]   devFnIn,
  input  logic [IN_W-1:0]   regOffIn,
  output logic              respValid,
  output logic              rangeErr,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [MAP_W-1:0]  mapVal
);

  localparam int FIELD_W   = 8;
  localparam int LEGAL_MAX = (1 << FIELD_W) - 1;

  cfgStrobe_t strobes;

  cfgaddr_ctrl #(
    .IN_W      (IN_W),
    .LEGAL_MAX (LEGAL_MAX)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .busIn     (busIn),
    .devFnIn   (devFnIn),
    .regOffIn  (regOffIn),
    .strobes   (strobes),
    .respValid (respValid),
    .rangeErr  (rangeErr)
  );

  cfgaddr_dpath #(
    .FIELD_W      (FIELD_W),
    .ADDR_W       (ADDR_W),
    .MAP_W        (MAP_W),
    .LOW_SLOT_MAX (12)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busNum  (busIn[FIELD_W-1:0]),
    .devFn   (devFnIn[FIELD_W-1:0]),
    .regOff  (regOffIn[FIELD_W-1:0]),
    .cfgAddr (cfgAddr),
    .mapVal  (mapVal)
  );

endmodule

// File: tb/test_cfgAddrGen.sv
module test_cfgAddrGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [9:0]  busIn = '0;
  logic [9:0]  devFnIn = '0;
  logic [9:0]  regOffIn = '0;
  logic        respValid;
  logic        rangeErr;
  logic [31:0] cfgAddr;
  logic [31:0] mapVal;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  cfgAddrGen i_cfgAddrGen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .busIn(busIn), .devFnIn(devFnIn), .regOffIn(regOffIn),
    .respValid(respValid), .rangeErr(rangeErr),
    .cfgAddr(cfgAddr), .mapVal(mapVal)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected values built from the requirement text
  task automatic model(input int bus, input int df, input int off,
                       output logic [31:0] ea, output logic [31:0] em);
    int slot = df >> 3;
    if (bus == 0) begin
      ea = 32'((df & 7) << 8);
      em = 32'hA;
      if (slot <= 12) ea = ea | (32'd1 << (slot + 11));
      else            em = em | (32'd1 << (slot - 5));
    end else begin
      ea = 32'((bus << 16) | (df << 8));
      em = 32'hB;
    end
    ea = ea + 32'(off);
  endtask

  // Drive one request at a falling edge, sample one clock later
  task automatic issue(input int bus, input int df, input int off);
    @(negedge clk);
    busIn = 10'(bus); devFnIn = 10'(df); regOffIn = 10'(off);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic runLegal(input string req, input int bus, input int df, input int off);
    logic [31:0] ea, em;
    model(bus, df, off, ea, em);
    issue(bus, df, off);
    check({req, " valid"}, 32'(respValid), 32'd1);
    check({req, " err"}, 32'(rangeErr), 32'd0);
    check({req, " addr"}, cfgAddr, ea);
    check({req, " map"}, mapVal, em);
  endtask

  task automatic testReset();
    check("R1 valid", 32'(respValid), 0);
    check("R1 err", 32'(rangeErr), 0);
    check("R1 addr", cfgAddr, 0);
    check("R1 map", mapVal, 0);
  endtask

  task automatic testType0Low();
    runLegal("R4 slot0", 0, 8'h00, 0);
    runLegal("R4 slot12 fn7 R8", 0, (12 << 3) | 7, 8'hFC);
    runLegal("R3 R8 slot5 fn2", 0, (5 << 3) | 2, 8'h13);
  endtask

  task automatic testType0High();
    runLegal("R5 slot13", 0, 13 << 3, 8'h04);
    runLegal("R5 R7 slot31 fn5", 0, (31 << 3) | 5, 8'h40);
  endtask

  task automatic testType1();
    runLegal("R6 bus1", 1, 8'h2A, 8'h10);
    runLegal("R6 R3 R8 all ones", 255, 255, 255);
  endtask

  task automatic testRange();
    issue(256, 0, 0);
    check("R9 bus err", 32'(rangeErr), 1);
    check("R9 bus valid", 32'(respValid), 1);
    check("R9 bus addr", cfgAddr, 0);
    check("R9 bus map", mapVal, 0);
    issue(0, 300, 0);
    check("R9 devfn err", 32'(rangeErr), 1);
    issue(3, 8, 1023);
    check("R9 off err", 32'(rangeErr), 1);
    check("R9 off addr", cfgAddr, 0);
    runLegal("R9 recover", 0, 8'h08, 8'h00);
  endtask

  task automatic testHoldAndPulse();
    logic [31:0] ea, em;
    model(7, 8'h55, 8'h20, ea, em);
    issue(7, 8'h55, 8'h20);
    @(negedge clk);
    check("R2 pulse drop", 32'(respValid), 0);
    repeat (3) @(negedge clk);
    check("R10 addr hold", cfgAddr, ea);
    check("R10 map hold", mapVal, em);
    check("R10 err hold", 32'(rangeErr), 0);
    // back-to-back requests keep respValid high
    @(negedge clk);
    busIn = 0; devFnIn = 10'h10; regOffIn = 0; reqValid = 1'b1;
    @(negedge clk);
    busIn = 2;
    check("R2 back1", 32'(respValid), 1);
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 back2", 32'(respValid), 1);
    check("R3 back2 type1", mapVal, 32'hB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testType0Low();
    testType0High();
    testType1();
    testRange();
    testHoldAndPulse();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule